// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Block Refill

This block sits between a processor load port and a slower, word-wide backing memory. It serves read requests only. Each 32-bit byte address splits into four fields, from high bits to low: a tag, a line index, a word offset within the line, and a two-bit byte offset. The byte offset plays no part in the lookup. Every address maps to exactly one line. A line holds one valid bit, one tag and a block of several words.

A hit returns the selected word in the same cycle as the request. A miss brings in the whole block that holds the requested word. The block is read from memory one word at a time, starting at the block-aligned address and moving up through the word offsets. The fill overwrites whatever the indexed line held before. The valid bit and the tag are written only when the final word arrives. The request is answered in the following cycle.

Two counters record hits and misses. The sizes are parameters: `CACHE_BYTES` and `LINE_BYTES` set the capacity and the line size, and all field widths are derived from them. The default is 4 KB with 16-byte lines. A 16 KB cache with 64-byte lines is set up in the same way.

Top module: `dmc_read_cache`

## Requirements
- R1: During and after reset, `cpu_ready` and `mem_req` are low and both counters are zero. Every line is invalid, so the first access to any line misses.
- R2: A hit (the line is valid and its stored tag equals the address tag) raises `cpu_ready` in the same cycle as `cpu_req`, with `cpu_rdata` set to the addressed word. A hit makes no memory request.
- R3: A miss issues exactly WORDS (LINE_BYTES/4) single-word reads. Their addresses are the block base plus 4*k, for k rising from 0. Each read holds `mem_req` high and `mem_addr` stable until `mem_ack`.
- R4: On a miss, `cpu_ready` stays low until the cycle after the final `mem_ack`. It then rises for one cycle with the requested word.
- R5: With the default parameters, the index is address bits [11:4] (256 lines) and the tag is bits [31:12]. A miss to an index that holds another tag replaces that line, so the old address misses again afterwards.
- R6: Address bits [1:0] are ignored. Addresses that differ only in those bits return the same word and hit the same line.
- R7: After a refill, every other word of the same block hits without any memory request.
- R8: `hit_count` rises by one per hit and `miss_count` by one per miss. Neither counter changes at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Read request; held with `cpu_addr` until `cpu_ready` |
| cpu_addr | input | 32 | Byte address of the load |
| cpu_ready | output | 1 | Word on `cpu_rdata` is valid this cycle |
| cpu_rdata | output | 32 | Returned word |
| mem_req | output | 1 | Single-word memory read request |
| mem_addr | output | 32 | Word-aligned memory read address |
| mem_ack | input | 1 | Memory read data valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| hit_count | output | CNT_W | Number of hits since reset |
| miss_count | output | CNT_W | Number of misses since reset |

## Verification
The hardest case to reach from the ports is a conflict eviction. It needs two addresses with the same index but different tags, used in an order that makes a line that was valid and matching miss again. The stimulus builds these pairs by changing only bit 12 and higher. It then returns to the first address and expects a full refill, not a hit. The memory model varies its acknowledge latency from word to word. This checks that the fill order and address hold do not depend on timing, and that the response waits for the last word however long the memory takes.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_LOOK = 2'd0,
    ST_FILL = 2'd1,
    ST_RESP = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_array.sv
module dmc_tag_array #(
  parameter int LINES = 256,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
endmodule

// File: rtl/dmc_data_array.sv
module dmc_data_array #(
  parameter int LINES  = 256,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int DEPTH = LINES * WORDS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_idx, wr_off}] <= wr_data;
  end

  assign rd_data = mem[{rd_idx, rd_off}];
endmodule

// File: rtl/dmc_fill_ctrl.sv
module dmc_fill_ctrl
  import dmc_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_fill,
  input  logic             mem_ack,
  output dmc_state_e       state,
  output logic [OFF_W-1:0] word_cnt,
  output logic             word_wr,
  output logic             last_wr
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  assign word_wr = (state == ST_FILL) && mem_ack;
  assign last_wr = word_wr && (word_cnt == LAST_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_LOOK;
      word_cnt <= '0;
    end else begin
      unique case (state)
        ST_LOOK: begin
          word_cnt <= '0;
          if (start_fill) state <= ST_FILL;
        end
        ST_FILL: begin
          if (word_wr) word_cnt <= word_cnt + 1'b1;
          if (last_wr) state <= ST_RESP;
        end
        default: state <= ST_LOOK;
      endcase
    end
  end
endmodule

// File: rtl/dmc_read_cache.sv
module dmc_read_cache
  import dmc_pkg::*;
#(
  parameter int CACHE_BYTES = 4096,
  parameter int LINE_BYTES  = 16,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic [31:0]      cpu_addr,
  output logic             cpu_ready,
  output logic [31:0]      cpu_rdata,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int LINES  = CACHE_BYTES / LINE_BYTES;
  localparam int BYTE_W = 2;
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = 32 - IDX_W - OFF_W - BYTE_W;
  localparam int IDX_LO = BYTE_W + OFF_W;
  localparam int TAG_LO = IDX_LO + IDX_W;

  function automatic logic [TAG_W-1:0] addr_tag(input logic [31:0] a);
    return a[31:TAG_LO];
  endfunction
  function automatic logic [IDX_W-1:0] addr_idx(input logic [31:0] a);
    return a[TAG_LO-1:IDX_LO];
  endfunction
  function automatic logic [OFF_W-1:0] addr_off(input logic [31:0] a);
    return a[IDX_LO-1:BYTE_W];
  endfunction
  function automatic logic [31:0] fill_addr(input logic [TAG_W-1:0] t,
                                            input logic [IDX_W-1:0] i,
                                            input logic [OFF_W-1:0] o);
    return {t, i, o, {BYTE_W{1'b0}}};
  endfunction

  dmc_state_e       state;
  logic [OFF_W-1:0] word_cnt;
  logic             word_wr;
  logic             last_wr;
  logic [31:0]      held_addr;
  logic [31:0]      look_addr;
  logic             line_valid;
  logic [TAG_W-1:0] line_tag;

  // named events used by the checker
  logic st_look, st_fill, ev_hit, ev_miss, ev_fill_last;

  assign st_look      = (state == ST_LOOK);
  assign st_fill      = (state == ST_FILL);
  assign look_addr    = st_look ? cpu_addr : held_addr;
  assign ev_hit       = st_look && cpu_req && line_valid &&
                        (line_tag == addr_tag(cpu_addr));
  assign ev_miss      = st_look && cpu_req && !ev_hit;
  assign ev_fill_last = last_wr;

  dmc_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (addr_idx(look_addr)),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .wr_en    (last_wr),
    .wr_idx   (addr_idx(held_addr)),
    .wr_tag   (addr_tag(held_addr))
  );

  dmc_data_array #(.LINES(LINES), .WORDS(WORDS), .DATA_W(32)) u_data (
    .clk     (clk),
    .rd_idx  (addr_idx(look_addr)),
    .rd_off  (addr_off(look_addr)),
    .rd_data (cpu_rdata),
    .wr_en   (word_wr),
    .wr_idx  (addr_idx(held_addr)),
    .wr_off  (word_cnt),
    .wr_data (mem_rdata)
  );

  dmc_fill_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_fill (ev_miss),
    .mem_ack    (mem_ack),
    .state      (state),
    .word_cnt   (word_cnt),
    .word_wr    (word_wr),
    .last_wr    (last_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) held_addr <= '0;
    else if (ev_miss) held_addr <= cpu_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (ev_hit)  hit_count  <= hit_count + 1'b1;
      if (ev_miss) miss_count <= miss_count + 1'b1;
    end
  end

  assign cpu_ready = ev_hit || (state == ST_RESP);
  assign mem_req   = st_fill;
  assign mem_addr  = fill_addr(addr_tag(held_addr), addr_idx(held_addr), word_cnt);
endmodule

// File: rtl/dmc_read_cache_chk.sv
module dmc_read_cache_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_ready,
  input logic             mem_req,
  input logic [31:0]      mem_addr,
  input logic             mem_ack,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count,
  input logic             st_fill,
  input logic             ev_hit,
  input logic             ev_miss,
  input logic             ev_fill_last
);
  a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> !mem_req);

  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  a_r4_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_last |=> cpu_ready);

  a_r4_no_ready_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    st_fill |-> !cpu_ready);

  a_r8_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (hit_count == $past(hit_count) + CNT_W'(1)));

  a_r8_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_hit |=> $stable(hit_count));

  a_r8_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (miss_count == $past(miss_count) + CNT_W'(1)));

  a_r8_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_miss |=> $stable(miss_count));
endmodule

bind dmc_read_cache dmc_read_cache_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_ready    (cpu_ready),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_ack      (mem_ack),
  .hit_count    (hit_count),
  .miss_count   (miss_count),
  .st_fill      (st_fill),
  .ev_hit       (ev_hit),
  .ev_miss      (ev_miss),
  .ev_fill_last (ev_fill_last)
);

// File: tb/sim_dmc_read_cache.sv
module sim_dmc_read_cache;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 4;
  localparam int CNT_W      = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cpu_req = 1'b0;
  logic [31:0]      cpu_addr = '0;
  logic             cpu_ready;
  logic [31:0]      cpu_rdata;
  logic             mem_req;
  logic [31:0]      mem_addr;
  logic             mem_ack = 1'b0;
  logic [31:0]      mem_rdata = '0;
  logic [CNT_W-1:0] hit_count;
  logic [CNT_W-1:0] miss_count;

  int checks = 0;
  int errors = 0;
  int exp_hits = 0;
  int exp_misses = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] addr;
    bit          hit;
    string       req;
  } exp_t;
  exp_t        rsp_q[$];
  logic [31:0] mem_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmc_read_cache #(.CACHE_BYTES(4096), .LINE_BYTES(16), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  function automatic logic [31:0] backing(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A3C_0F96;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: pushes expectations, then drives the request until answered
  task automatic access(input logic [31:0] a, input bit hit, input string req);
    exp_t e;
    e.addr = a; e.hit = hit; e.req = req;
    rsp_q.push_back(e);
    if (hit) exp_hits++;
    else begin
      exp_misses++;
      for (int k = 0; k < WORDS; k++)
        mem_q.push_back({a[31:4], 4'b0000} + 32'(4 * k));
    end
    cpu_req  = 1'b1;
    cpu_addr = a;
    do @(negedge clk); while (!cpu_ready);
    @(posedge clk); #1;
  endtask

  task automatic go_idle(input int n);
    cpu_req = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: pops expectations as responses appear
  int waits = 0;
  always @(negedge clk) begin
    if (rst_n && cpu_req) begin
      if (cpu_ready) begin
        if (rsp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected response", cpu_rdata, 32'h0);
        end else begin
          exp_t e;
          e = rsp_q.pop_front();
          chk(cpu_rdata === backing(e.addr), e.req, cpu_rdata, backing(e.addr));
          if (e.hit)
            chk(waits == 0, "R2 hit answered in request cycle", 32'(waits), 32'd0);
          else
            chk(waits >= WORDS, "R4 miss answered after full refill",
                32'(waits), 32'(WORDS));
        end
        waits = 0;
      end else begin
        waits++;
      end
    end
  end

  // backing memory model with varying latency
  int mwait = 0;
  int acks = 0;
  initial begin
    forever begin
      @(posedge clk); #1;
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (rst_n && mem_req) begin
        if (mwait >= (acks % 3)) begin
          if (mem_q.size() == 0) begin
            chk(1'b0, "R3 unexpected memory read", mem_addr, 32'h0);
          end else begin
            logic [31:0] ea;
            ea = mem_q.pop_front();
            chk(mem_addr === ea, "R3 refill address order", mem_addr, ea);
          end
          mem_rdata = backing(mem_addr);
          mem_ack   = 1'b1;
          mwait     = 0;
          acks++;
        end else begin
          mwait++;
        end
      end
    end
  end

  initial begin
    repeat (CLK_PERIOD * 10000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(cpu_ready == 1'b0, "R1 ready low in reset", 32'(cpu_ready), 32'd0);
    chk(mem_req == 1'b0, "R1 mem_req low in reset", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(hit_count == 0, "R1 hit counter cleared", hit_count, 32'd0);
    chk(miss_count == 0, "R1 miss counter cleared", miss_count, 32'd0);

    // R1 R3 R4: first access misses and refills whole block
    access(32'h0000_0104, 1'b0, "R4 miss data");
    // R7: other words of the block now hit, back to back
    access(32'h0000_0108, 1'b1, "R7 neighbour word");
    access(32'h0000_010C, 1'b1, "R7 last word of block");
    access(32'h0000_0100, 1'b1, "R7 first word of block");
    // R6: byte offset ignored
    access(32'h0000_010B, 1'b1, "R6 byte offset ignored");
    access(32'h0000_0105, 1'b1, "R6 byte offset ignored");
    go_idle(3);
    chk(mem_q.size() == 0, "R2 no memory traffic on hits", 32'(mem_q.size()), 32'd0);

    // R5: same index 0x10, different tag evicts
    access(32'h0000_1104, 1'b0, "R5 conflicting tag misses");
    access(32'h0000_1100, 1'b1, "R5 new block resident");
    access(32'h0000_0104, 1'b0, "R5 evicted address misses again");
    access(32'h0000_1108, 1'b0, "R5 ping-pong eviction");
    go_idle(2);

    // R1: several fresh lines miss first, then hit
    for (int i = 0; i < 6; i++)
      access(32'h0002_0000 + 32'(i * 16) + 32'(4 * (i % 4)), 1'b0, "R1 fresh line miss");
    for (int i = 0; i < 6; i++)
      access(32'h0002_0000 + 32'(i * 16) + 32'(4 * ((i + 1) % 4)), 1'b1, "R7 fresh line hit");

    // R5: top of address space, index 255 and all-ones tag
    access(32'hFFFF_FFFC, 1'b0, "R5 top address miss");
    access(32'hFFFF_FFF0, 1'b1, "R5 top address hit");
    access(32'h0000_0FF4, 1'b0, "R5 index 255 other tag");
    access(32'hFFFF_FFF8, 1'b0, "R5 top address evicted");
    go_idle(4);

    chk(rsp_q.size() == 0, "R4 all requests answered", 32'(rsp_q.size()), 32'd0);
    chk(mem_q.size() == 0, "R3 all refill words read", 32'(mem_q.size()), 32'd0);
    chk(hit_count == 32'(exp_hits), "R8 hit counter", hit_count, 32'(exp_hits));
    chk(miss_count == 32'(exp_misses), "R8 miss counter", miss_count, 32'(exp_misses));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule